// File: doc/BRIEF.md
# Serial LED Cascade Driver

This block drives a chain of external 8-bit serial-in, parallel-out shift registers from a small set of 32-bit memory-mapped registers. The chain can hold up to three 8-bit groups, which gives 24 output lines. Each update shifts a 24-bit word out on a serial data line. A generated shift clock goes with it. After the last bit, a one-cycle store strobe makes all parallel outputs change at the same time.

Software starts an update by writing the control word with its update bit set. The block can also refresh the chain on its own from an internal timer, at one of four programmable rates. The eight lowest output lines can be taken away from the data register, one field at a time. Two of them can then follow status inputs from a modem core. Three can follow a first PHY and three a second PHY. A software request that arrives while a shift is running is held. It is served as soon as the running shift has finished.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, control 0 (byte offset 0x00) reads 0x8000_0000 and control 1 (0x04), data 0 (0x08), data 1 (0x0C) and the access register (0x10) read zero. `sh_store` is low and `sh_clk` rests low.
- R2: All five registers are read/write at the byte offsets listed in R1, and every one of their 32 bits reads back as written.
- R3: Control 1 bits 2:0 enable the groups. An update shifts 8*(k+1) bits, where k is the index of the highest set bit of that field. When the field is zero, a request is dropped and nothing is shifted.
- R4: An update shifts data 0 bits N-1 down to 0, the most significant bit first. Each bit takes 2*DIV_HALF system cycles, and `sh_dat` stays steady across the capture edge of `sh_clk`.
- R5: After each update `sh_store` pulses high for exactly one cycle. The pulse starts DIV_HALF cycles after the capture edge of the last bit.
- R6: A write to control 0 with bit 31 = 1 starts exactly one update. A write to control 0 with bit 31 = 0 starts none.
- R7: When control 0 bit 26 = 0, `sh_clk` rests low and bits are captured on its rising edge. When bit 26 = 1, it rests high and bits are captured on its falling edge.
- R8: When control 0 bit 24+i (i = 0,1) is set, output bit i comes from `modem_st[i]` instead of data 0.
- R9: When control 0 bit 27+i (i = 0..2) is set, output bit 2+i comes from `phya_st[i]`. When control 1 bit 15+i is set, output bit 5+i comes from `phyb_st[i]`.
- R10: When control 0 bit 31 = 0 and control 1 bits 31:30 = 2'b10, an update starts every PER_Rc cycles, where c is control 1 bits 24:23 (00..11 select PER_R0..PER_R3). With any other source code, no periodic update runs.
- R11: Software requests that arrive during a shift merge into one pending update. That update begins two cycles after the running update's store pulse, so the two store pulses are 2*DIV_HALF*N+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| modem_st | input | 2 | Modem status for output bits 1:0 |
| phya_st | input | 3 | First PHY status for output bits 4:2 |
| phyb_st | input | 3 | Second PHY status for output bits 7:5 |
| sh_clk | output | 1 | Shift clock to the cascade |
| sh_dat | output | 1 | Serial data to the cascade |
| sh_store | output | 1 | One-cycle store strobe to the cascade |

## Verification
A software update request can fall in the same cycles as a shift that is already running. The serial engine then has to merge the new request instead of restarting or dropping it. The bench provokes this by issuing one request, then two more during the first shift. It then expects exactly two store pulses, 2*DIV_HALF*N+2 cycles apart, and no third. The bench also sweeps every override mask, every group setting, both clock edges and all four timer rates. It compares each word it reconstructs from the serial line against a masked-merge formula.

// File: rtl/led_shift_pkg.sv
`timescale 1ns/1ps
package led_shift_pkg;
  localparam int LSC_GRP_W  = 8;
  localparam int LSC_NGRP   = 3;
  localparam int LSC_WORD_W = LSC_GRP_W * LSC_NGRP;

  // number of bits shifted for a group-enable field: set by the highest enabled group
  function automatic int unsigned lsc_bit_count(input logic [LSC_NGRP-1:0] grp);
    int unsigned n;
    n = 0;
    for (int g = 0; g < LSC_NGRP; g++)
      if (grp[g]) n = (g + 1) * LSC_GRP_W;
    return n;
  endfunction

  // merge data word with hardware status lines where an override is enabled
  function automatic logic [LSC_WORD_W-1:0] lsc_compose(
      input logic [LSC_WORD_W-1:0] dat,
      input logic [1:0] m_en, input logic [1:0] m_st,
      input logic [2:0] a_en, input logic [2:0] a_st,
      input logic [2:0] b_en, input logic [2:0] b_st);
    logic [LSC_WORD_W-1:0] w;
    w = dat;
    for (int i = 0; i < 2; i++) if (m_en[i]) w[i]     = m_st[i];
    for (int i = 0; i < 3; i++) if (a_en[i]) w[2 + i] = a_st[i];
    for (int i = 0; i < 3; i++) if (b_en[i]) w[5 + i] = b_st[i];
    return w;
  endfunction
endpackage

// File: rtl/lsc_regs.sv
`timescale 1ns/1ps
module lsc_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] ctl0,
  output logic [31:0] ctl1,
  output logic [31:0] dat0,
  output logic        sw_req
);
  logic [31:0] dat1, acc;
  logic [2:0]  slot;
  logic        wen;
  logic [1:0]  unused_lo;

  assign slot      = addr[4:2];
  assign wen       = sel & wr;
  assign unused_lo = addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0   <= 32'h8000_0000;
      ctl1   <= '0;
      dat0   <= '0;
      dat1   <= '0;
      acc    <= '0;
      sw_req <= 1'b0;
    end else begin
      sw_req <= wen && (slot == 3'd0) && wdata[31];
      if (wen) begin
        case (slot)
          3'd0: ctl0 <= wdata;
          3'd1: ctl1 <= wdata;
          3'd2: dat0 <= wdata;
          3'd3: dat1 <= wdata;
          3'd4: acc  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (slot)
      3'd0:    rdata = ctl0;
      3'd1:    rdata = ctl1;
      3'd2:    rdata = dat0;
      3'd3:    rdata = dat1;
      3'd4:    rdata = acc;
      default: rdata = '0;
    endcase
  end

  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) sw_req |-> $past(wen && wdata[31])); // R6
endmodule

// File: rtl/lsc_timer.sv
`timescale 1ns/1ps
module lsc_timer #(
  parameter int PER_R0 = 50_000_000,
  parameter int PER_R1 = 25_000_000,
  parameter int PER_R2 = 12_500_000,
  parameter int PER_R3 = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int PM01 = (PER_R0 > PER_R1) ? PER_R0 : PER_R1;
  localparam int PM23 = (PER_R2 > PER_R3) ? PER_R2 : PER_R3;
  localparam int PMAX = (PM01 > PM23) ? PM01 : PM23;
  localparam int CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt, lim;

  always_comb begin
    case (rate)
      2'd0:    lim = CW'(PER_R0 - 1);
      2'd1:    lim = CW'(PER_R1 - 1);
      2'd2:    lim = CW'(PER_R2 - 1);
      default: lim = CW'(PER_R3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) tick |-> $past(en)); // R10
endmodule

// File: rtl/lsc_shifter.sv
`timescale 1ns/1ps
module lsc_shifter
  import led_shift_pkg::*;
#(
  parameter int DIV_HALF = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig,
  input  logic                   fall_sel,
  input  logic [LSC_NGRP-1:0]    grp,
  input  logic [LSC_WORD_W-1:0]  word_in,
  output logic                   sh_clk,
  output logic                   sh_dat,
  output logic                   sh_store
);
  localparam int PER_BIT = 2 * DIV_HALF;
  localparam int CW      = (PER_BIT > 2) ? $clog2(PER_BIT) : 1;
  localparam int IW      = $clog2(LSC_WORD_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STORE} st_t;
  st_t st;

  logic [CW-1:0]         cnt;
  logic [IW-1:0]         idx, nbits, nbits_lat, edges_seen;
  logic [LSC_WORD_W-1:0] word_q;
  logic                  pend;
  logic                  start, last_half, phase, cap_edge;

  assign nbits     = IW'(lsc_bit_count(grp));
  assign start     = (st == S_IDLE) && (trig || pend) && (nbits != '0);
  assign last_half = (cnt == CW'(PER_BIT - 1));
  assign phase     = (cnt >= CW'(DIV_HALF));
  assign cap_edge  = (st == S_SHIFT) && (cnt == CW'(DIV_HALF));

  assign sh_clk   = fall_sel ^ ((st == S_SHIFT) && phase);
  assign sh_dat   = (st == S_SHIFT) ? word_q[idx] : 1'b0;
  assign sh_store = (st == S_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      word_q <= '0;
      pend   <= 1'b0;
    end else begin
      if (st != S_IDLE) begin
        if (trig) pend <= 1'b1;
      end else begin
        pend <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SHIFT;
          cnt    <= '0;
          idx    <= nbits - 1'b1;
          word_q <= word_in;
        end
        S_SHIFT: begin
          if (last_half) begin
            cnt <= '0;
            if (idx == '0) st <= S_STORE;
            else           idx <= idx - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // capture-edge counter kept for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_seen <= '0;
      nbits_lat  <= '0;
    end else if (start) begin
      edges_seen <= '0;
      nbits_lat  <= nbits;
    end else if (cap_edge) begin
      edges_seen <= edges_seen + 1'b1;
    end
  end

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sh_store |=> !sh_store); // R5
  AST_STORE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) sh_store |-> $past(st == S_SHIFT && last_half && idx == '0)); // R5
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n) sh_store |-> (edges_seen == nbits_lat)); // R3
  AST_DAT_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) cap_edge |-> $stable(sh_dat)); // R4
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE && pend && nbits != '0) |=> (st == S_SHIFT)); // R11
endmodule

// File: rtl/led_shift_ctrl.sv
`timescale 1ns/1ps
module led_shift_ctrl
  import led_shift_pkg::*;
#(
  parameter int DIV_HALF = 50,
  parameter int PER_R0   = 50_000_000,
  parameter int PER_R1   = 25_000_000,
  parameter int PER_R2   = 12_500_000,
  parameter int PER_R3   = 10_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  modem_st,
  input  logic [2:0]  phya_st,
  input  logic [2:0]  phyb_st,
  output logic        sh_clk,
  output logic        sh_dat,
  output logic        sh_store
);
  logic [31:0]           ctl0, ctl1, dat0;
  logic                  sw_req, tick, tmr_en;
  logic [LSC_WORD_W-1:0] word;
  logic                  unused_bits;

  assign tmr_en = !ctl0[31] && (ctl1[31:30] == 2'b10);
  assign word   = lsc_compose(dat0[LSC_WORD_W-1:0],
                              ctl0[25:24], modem_st,
                              ctl0[29:27], phya_st,
                              ctl1[17:15], phyb_st);
  assign unused_bits = ^{ctl0[30], ctl0[23:0], ctl1[29:25], ctl1[22:18],
                         ctl1[14:3], dat0[31:LSC_WORD_W]};

  lsc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctl0(ctl0), .ctl1(ctl1),
    .dat0(dat0), .sw_req(sw_req)
  );

  lsc_timer #(.PER_R0(PER_R0), .PER_R1(PER_R1), .PER_R2(PER_R2), .PER_R3(PER_R3)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .rate(ctl1[24:23]), .tick(tick)
  );

  lsc_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .trig(sw_req | tick), .fall_sel(ctl0[26]),
    .grp(ctl1[2:0]), .word_in(word), .sh_clk(sh_clk), .sh_dat(sh_dat),
    .sh_store(sh_store)
  );

  AST_TICK_ONLY_IN_TIMER_MODE: assert property (@(posedge clk) disable iff (!rst_n) tick |-> $past(ctl1[31:30] == 2'b10)); // R10
endmodule

// File: tb/led_shift_ctrl_test.sv
`timescale 1ns/1ps
module led_shift_ctrl_test;
  localparam int TB_DIV = 1;
  localparam int P0 = 200, P1 = 160, P2 = 120, P3 = 100;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0] modem_st = 0;
  logic [2:0] phya_st = 0, phyb_st = 0;
  logic sh_clk, sh_dat, sh_store;

  int checks = 0, failures = 0;
  int cyc = 0, stores = 0, ncap = 0, last_n = 0, dbl = 0;
  int t_last = 0, t_prev = 0, t_edge = 0;
  logic [23:0] cap = 0, last_word = 0;
  logic prev_clk = 0, prev_store = 0, tb_fall = 0;

  led_shift_ctrl #(.DIV_HALF(TB_DIV), .PER_R0(P0), .PER_R1(P1), .PER_R2(P2), .PER_R3(P3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modem_st(modem_st), .phya_st(phya_st),
    .phyb_st(phyb_st), .sh_clk(sh_clk), .sh_dat(sh_dat), .sh_store(sh_store)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // serial-line monitor: rebuilds each shifted word independently of the design
  always @(negedge clk) begin
    if (rst_n) begin
      if (sh_clk !== prev_clk && sh_clk == !tb_fall) begin
        cap = {cap[22:0], sh_dat};
        ncap++;
        t_edge = cyc;
      end
      if (sh_store) begin
        if (prev_store) dbl++;
        last_word = cap; last_n = ncap; cap = 0; ncap = 0;
        t_prev = t_last; t_last = cyc; stores++;
      end
    end
    prev_clk = sh_clk;
    prev_store = sh_store;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_stores(input int target, input int limit, output bit ok);
    ok = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk); #1;
      if (stores >= target) begin ok = 1; break; end
    end
  endtask

  function automatic int nbits_of(input logic [2:0] g);
    return g[2] ? 24 : (g[1] ? 16 : (g[0] ? 8 : 0));
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] d, input logic [7:0] en,
                                              input logic [7:0] hw, input int n);
    logic [23:0] w;
    w = (d & ~{16'h0, en}) | {16'h0, hw & en};
    if (n < 24) w = w & ((24'h1 << n) - 24'h1);
    return w;
  endfunction

  // one software update with full configuration, checked against the formula
  task automatic sw_update(input logic [23:0] d, input logic [2:0] g, input bit fall,
                           input logic [1:0] me, input logic [2:0] ae, input logic [2:0] be,
                           input string tag);
    int s0, n; bit ok;
    logic [31:0] c0;
    n = nbits_of(g);
    wr(5'h08, {8'h0, d});
    wr(5'h04, {14'h0, be, 12'h0, g});
    tb_fall = fall;
    s0 = stores;
    c0 = 32'h8000_0000 | (32'(ae) << 27) | (32'(fall) << 26) | (32'(me) << 24);
    wr(5'h00, c0);
    wait_stores(s0 + 1, 200, ok);
    chk(ok, {tag, " store seen"}, stores - s0, 1);
    chk(last_n == n, {tag, " bit count"}, last_n, n);
    chk(last_word == expect_word(d, {be, ae, me}, {phyb_st, phya_st, modem_st}, n),
        {tag, " word"}, last_word, expect_word(d, {be, ae, me}, {phyb_st, phya_st, modem_st}, n));
  endtask

  initial begin
    logic [31:0] rv;
    bit ok;
    int s0;
    logic [23:0] pats [5];
    pats[0] = 24'hA5C3F0; pats[1] = 24'h5A3C0F; pats[2] = 24'hFFFFFF;
    pats[3] = 24'h000001; pats[4] = 24'h800000;

    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(5'h00, rv); chk(rv == 32'h8000_0000, "R1 ctl0 reset", rv, 32'h8000_0000);
    rd(5'h04, rv); chk(rv == 0, "R1 ctl1 reset", rv, 0);
    rd(5'h08, rv); chk(rv == 0, "R1 dat0 reset", rv, 0);
    rd(5'h0C, rv); chk(rv == 0, "R1 dat1 reset", rv, 0);
    rd(5'h10, rv); chk(rv == 0, "R1 acc reset", rv, 0);
    chk(sh_store == 0 && sh_clk == 0, "R1 idle outputs", {sh_store, sh_clk}, 0);

    // R2 readback, control 0 written with bit 31 clear so no update starts
    wr(5'h00, 32'h5A5A_1234); rd(5'h00, rv); chk(rv == 32'h5A5A_1234, "R2 ctl0", rv, 32'h5A5A_1234);
    wr(5'h04, 32'h3C3C_A5A5); rd(5'h04, rv); chk(rv == 32'h3C3C_A5A5, "R2 ctl1", rv, 32'h3C3C_A5A5);
    wr(5'h08, 32'hDEAD_BEEF); rd(5'h08, rv); chk(rv == 32'hDEAD_BEEF, "R2 dat0", rv, 32'hDEAD_BEEF);
    wr(5'h0C, 32'h1357_9BDF); rd(5'h0C, rv); chk(rv == 32'h1357_9BDF, "R2 dat1", rv, 32'h1357_9BDF);
    wr(5'h10, 32'hFFFF_0001); rd(5'h10, rv); chk(rv == 32'hFFFF_0001, "R2 acc", rv, 32'hFFFF_0001);
    tb_fall = 0;
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);

    // R3 groups zero: request dropped
    s0 = stores;
    wr(5'h00, 32'h8000_0000);
    repeat (80) @(negedge clk);
    chk(stores == s0, "R3 zero groups no shift", stores - s0, 0);

    // R3 R4 R7 sweep of group fields, patterns and edges
    for (int e = 0; e < 2; e++)
      for (int g = 1; g < 8; g++)
        for (int p = 0; p < 5; p++)
          sw_update(pats[p], 3'(g), e[0], 2'b0, 3'b0, 3'b0, "R3 R4 R7 sweep");

    // R7 resting level in falling mode
    tb_fall = 1;
    wr(5'h00, 32'h0400_0000);
    @(negedge clk); chk(sh_clk == 1, "R7 falling idle high", sh_clk, 1);
    tb_fall = 0;
    wr(5'h00, 32'h0);
    @(negedge clk); chk(sh_clk == 0, "R7 rising idle low", sh_clk, 0);

    // R5 store timing and width
    sw_update(24'h0000C3, 3'b001, 0, 2'b0, 3'b0, 3'b0, "R5 base");
    chk(t_last - t_edge == TB_DIV, "R5 store after last edge", t_last - t_edge, TB_DIV);
    chk(dbl == 0, "R5 single cycle store", dbl, 0);

    // R8 R9 every override mask
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          {phyb_st, phya_st, modem_st} = 8'((m * 37 + a * 11 + b * 5) ^ 8'h96);
          sw_update(((m + a + b) % 2 == 0) ? 24'h0000FF : 24'h000000, 3'b001, 0,
                    2'(m), 3'(a), 3'(b), "R8 R9 override");
        end
    {phyb_st, phya_st, modem_st} = 8'h0;

    // R6 write with bit 31 clear starts nothing
    s0 = stores;
    wr(5'h00, 32'h0000_0000);
    repeat (60) @(negedge clk);
    chk(stores == s0, "R6 no trigger without bit31", stores - s0, 0);

    // R11 requests during a shift merge into one, served right after store
    wr(5'h04, 32'h1); wr(5'h08, 32'h5A);
    s0 = stores;
    wr(5'h00, 32'h8000_0000);
    repeat (3) @(negedge clk);
    wr(5'h00, 32'h8000_0000);
    wr(5'h00, 32'h8000_0000);
    wait_stores(s0 + 2, 200, ok);
    chk(ok, "R11 pending served", stores - s0, 2);
    chk(t_last - t_prev == 2 * TB_DIV * 8 + 2, "R11 back-to-back spacing", t_last - t_prev, 2 * TB_DIV * 8 + 2);
    chk(last_word == 24'h5A, "R11 pending word", last_word, 24'h5A);
    repeat (60) @(negedge clk);
    chk(stores == s0 + 2, "R11 requests merged", stores - s0, 2);

    // R10 periodic rates
    for (int r = 0; r < 4; r++) begin
      int per;
      per = (r == 0) ? P0 : (r == 1) ? P1 : (r == 2) ? P2 : P3;
      wr(5'h04, 32'h8000_0001 | (32'(r) << 23));
      wr(5'h00, 32'h0);
      s0 = stores;
      wait_stores(s0 + 3, 4 * per, ok);
      chk(ok, "R10 periodic running", stores - s0, 3);
      chk(t_last - t_prev == per, "R10 periodic interval", t_last - t_prev, per);
      wr(5'h00, 32'h8000_0000);
      wait_stores(stores + 1, 100, ok);
    end
    wr(5'h04, 32'h4000_0001);
    wr(5'h00, 32'h0);
    repeat (30) @(negedge clk);
    s0 = stores;
    repeat (300) @(negedge clk);
    chk(stores == s0, "R10 other source no periodic", stores - s0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule